// File: doc/BRIEF.md
# Column-Addressed Triple-Redundant Configuration Store

This block holds the configuration bits of a pixel array arranged as a set of columns. Each column pairs a serial staging register of flip-flops with an equal number of configuration cells. Every cell keeps three copies of its bit and drives a majority-voted value to the pixels. One serial port, a column address and a small set of control strobes reach every column. The address decides which column sees the strobes. All other columns hold still.

To configure a column, software shifts a word of `CHAIN_LEN` bits through the staging register and then pulses load. Load writes the staging bits into all three copies of each cell. To verify, it pulses readback, which copies the voted cell values into the staging register, and then shifts them out on the serial output. The serial output is a multiplexer steered by the same address. Clear zeroes the staging register of the addressed column and does not touch the cells. An upset-injection input flips one copy of one cell. It models a single-event upset, so the voting can be exercised.

Top module: `cfg_shift_store`

## Requirements
- R1: After the active-low reset `rst_ni`, every staging bit and every cell copy is 0. So `cfg_o` is all zero and `sdo_o` is 0.
- R2: In a cycle where `shift_i` is the only strobe asserted, the addressed column moves its staging register one stage: `sdi_i` enters stage 0, and stage k moves to stage k+1. Configuration cells are unchanged by shifting.
- R3: Only the column whose index equals `col_addr_i` reacts to strobes and upset injection. Every other column keeps its staging register and its cell values.
- R4: `sdo_o` shows the last stage (index `CHAIN_LEN-1`) of the addressed column's staging register. It follows `col_addr_i` within the same cycle.
- R5: A load writes staging stage i into all three copies of cell i of the addressed column. After the load, `cfg_o[col*CHAIN_LEN + i]` equals that bit, and the staging register keeps its contents.
- R6: A readback writes the voted value of cell i into staging stage i. Shifting then presents cell `CHAIN_LEN-1` first on `sdo_o`.
- R7: When several strobes are asserted in one cycle, only one of them acts, in this priority order: clear, then readback, then load, then shift. For example, readback together with load leaves the cells unchanged.
- R8: A clear sets the addressed staging register to all zero and leaves its cells unchanged.
- R9: Flipping a single copy of a cell whose three copies agree leaves the voted output unchanged. Flipping a second copy of the same cell inverts the voted output. A later load rewrites all three copies.
- R10: `upset_copy_i` selects the copy to flip: 0, 1 or 2. The value 3 flips nothing. `upset_idx_i` selects the cell index within the addressed column. An upset in the same cycle as a load is overridden by the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| col_addr_i | input | $clog2(NUM_COLS) | Column selected for strobes, upset and serial output |
| sdi_i | input | 1 | Serial data into stage 0 |
| shift_i | input | 1 | Shift the addressed staging register one stage |
| load_i | input | 1 | Copy staging register into all cell copies |
| rdbk_i | input | 1 | Copy voted cell values into staging register |
| clear_i | input | 1 | Zero the addressed staging register |
| upset_i | input | 1 | Flip one copy of one cell |
| upset_copy_i | input | 2 | Copy index to flip (3 means none) |
| upset_idx_i | input | $clog2(CHAIN_LEN) | Cell index to flip |
| sdo_o | output | 1 | Last staging stage of the addressed column |
| cfg_o | output | NUM_COLS*CHAIN_LEN | Voted configuration, column c at bits c*CHAIN_LEN upward |

## Verification
The bench writes a distinct pattern into every column and checks the whole configuration image after each load. If the address decode were wrong, a load would land in a neighbouring column, and the bits of an untouched column would change. Readback followed by a full shift-out checks bit order end to end. A reversed chain or a voter that read the wrong copy would return a mirrored or stale word. The bench also asserts combined strobes (readback with load, clear with everything, shift with load) and injects single, double and invalid-copy upsets. A wrong priority, a load that rewrote only one copy, or a voter that passed one copy straight through would each show up as a flipped configuration bit.

// File: rtl/cfg_chain_pkg.sv
package cfg_chain_pkg;

  localparam int unsigned NUM_COPIES = 3;

  typedef enum logic [2:0] {
    OP_IDLE,
    OP_SHIFT,
    OP_LOAD,
    OP_RDBK,
    OP_CLEAR
  } chain_op_e;

  // one action per cycle, clear first
  function automatic chain_op_e pick_op(input logic shift, input logic load,
                                        input logic rdbk, input logic clear);
    if (clear)      return OP_CLEAR;
    else if (rdbk)  return OP_RDBK;
    else if (load)  return OP_LOAD;
    else if (shift) return OP_SHIFT;
    return OP_IDLE;
  endfunction

endpackage

// File: rtl/tmr_vote.sv
module tmr_vote #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] c_i,
  output logic [W-1:0] y_o
);
  assign y_o = (a_i & b_i) | (a_i & c_i) | (b_i & c_i);
endmodule

// File: rtl/tmr_bank.sv
module tmr_bank
  import cfg_chain_pkg::*;
#(
  parameter int unsigned W  = 256,
  parameter int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          flip_i,
  input  logic [1:0]    flip_copy_i,
  input  logic [IW-1:0] flip_idx_i,
  output logic [W-1:0]  voted_o
);

  logic [W-1:0] copy_w [NUM_COPIES];
  logic [W-1:0] flip_mask;

  assign flip_mask = W'(1) << flip_idx_i;

  for (genvar k = 0; k < NUM_COPIES; k++) begin : g_copy
    logic [W-1:0] q;
    logic         hit;
    assign hit = flip_i && (flip_copy_i == 2'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  q <= '0;
      else if (wr_i) q <= wr_data_i;
      else if (hit)  q <= q ^ flip_mask;
    end
    assign copy_w[k] = q;
  end

  tmr_vote #(.W(W)) u_vote (
    .a_i(copy_w[0]),
    .b_i(copy_w[1]),
    .c_i(copy_w[2]),
    .y_o(voted_o)
  );

  AST_WRITE_ALL_COPIES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (copy_w[0] == $past(wr_data_i)) && (copy_w[1] == $past(wr_data_i))
             && (copy_w[2] == $past(wr_data_i))); // R5

  AST_SINGLE_UPSET_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && flip_i && (copy_w[0] == copy_w[1]) && (copy_w[1] == copy_w[2]))
      |=> $stable(voted_o)); // R9

  AST_NO_COPY3_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_i && flip_i && (flip_copy_i == 2'd3))
      |=> $stable(copy_w[0]) && $stable(copy_w[1]) && $stable(copy_w[2])); // R10

endmodule

// File: rtl/chain_column.sv
module chain_column
  import cfg_chain_pkg::*;
#(
  parameter int unsigned LEN = 256,
  parameter int unsigned IW  = (LEN > 1) ? $clog2(LEN) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           sel_i,
  input  logic           sdi_i,
  input  logic           shift_i,
  input  logic           load_i,
  input  logic           rdbk_i,
  input  logic           clear_i,
  input  logic           flip_i,
  input  logic [1:0]     flip_copy_i,
  input  logic [IW-1:0]  flip_idx_i,
  output logic           sdo_o,
  output logic [LEN-1:0] cfg_o
);

  chain_op_e      op;
  logic [LEN-1:0] sr_q;
  logic [LEN-1:0] voted;
  logic           bank_wr;
  logic           bank_flip;

  assign op        = sel_i ? pick_op(shift_i, load_i, rdbk_i, clear_i) : OP_IDLE;
  assign bank_wr   = (op == OP_LOAD);
  assign bank_flip = sel_i && flip_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sr_q <= '0;
    end else begin
      case (op)
        OP_CLEAR: sr_q <= '0;
        OP_RDBK:  sr_q <= voted;
        OP_SHIFT: begin
          if (LEN > 1) sr_q <= {sr_q[LEN-2:0], sdi_i};
          else         sr_q <= sdi_i;
        end
        default:  sr_q <= sr_q;
      endcase
    end
  end

  tmr_bank #(.W(LEN), .IW(IW)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (bank_wr),
    .wr_data_i  (sr_q),
    .flip_i     (bank_flip),
    .flip_copy_i(flip_copy_i),
    .flip_idx_i (flip_idx_i),
    .voted_o    (voted)
  );

  assign sdo_o = sr_q[LEN-1];
  assign cfg_o = voted;

  AST_SHIFT_ENTRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && shift_i && !load_i && !rdbk_i && !clear_i)
      |=> (sr_q[0] == $past(sdi_i)) && $stable(voted)); // R2

  AST_UNSEL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(sr_q) && $stable(voted)); // R3

  AST_LOAD_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && load_i && !rdbk_i && !clear_i)
      |=> (voted == $past(sr_q)) && $stable(sr_q)); // R5

  AST_RDBK_COPY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && rdbk_i && !clear_i && !flip_i)
      |=> (sr_q == $past(voted)) && $stable(voted)); // R7

  AST_CLEAR_KEEPS_CELLS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && clear_i && !flip_i) |=> (sr_q == '0) && $stable(voted)); // R8

endmodule

// File: rtl/cfg_shift_store.sv
module cfg_shift_store
  import cfg_chain_pkg::*;
#(
  parameter int unsigned NUM_COLS  = 16,
  parameter int unsigned CHAIN_LEN = 256,
  localparam int unsigned AW = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1,
  localparam int unsigned IW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1,
  localparam int unsigned CW = NUM_COLS * CHAIN_LEN
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] col_addr_i,
  input  logic          sdi_i,
  input  logic          shift_i,
  input  logic          load_i,
  input  logic          rdbk_i,
  input  logic          clear_i,
  input  logic          upset_i,
  input  logic [1:0]    upset_copy_i,
  input  logic [IW-1:0] upset_idx_i,
  output logic          sdo_o,
  output logic [CW-1:0] cfg_o
);

  logic [NUM_COLS-1:0] col_sel;
  logic [NUM_COLS-1:0] col_sdo;

  for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
    assign col_sel[c] = (col_addr_i == AW'(c));

    chain_column #(.LEN(CHAIN_LEN), .IW(IW)) u_col (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .sel_i      (col_sel[c]),
      .sdi_i      (sdi_i),
      .shift_i    (shift_i),
      .load_i     (load_i),
      .rdbk_i     (rdbk_i),
      .clear_i    (clear_i),
      .flip_i     (upset_i),
      .flip_copy_i(upset_copy_i),
      .flip_idx_i (upset_idx_i),
      .sdo_o      (col_sdo[c]),
      .cfg_o      (cfg_o[c*CHAIN_LEN +: CHAIN_LEN])
    );
  end

  always_comb begin
    sdo_o = 1'b0;
    for (int c = 0; c < NUM_COLS; c++) begin
      if (col_sel[c]) sdo_o = col_sdo[c];
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !load_i && !rdbk_i && !clear_i && !upset_i) |=> $stable(cfg_o)); // R3

  AST_SDO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!shift_i && !rdbk_i && !clear_i) ##1 $stable(col_addr_i) |-> $stable(sdo_o)); // R4

endmodule

// File: tb/sim_cfg_shift_store.sv
`timescale 1ns/1ps
module sim_cfg_shift_store;
  localparam int NC  = 16;
  localparam int LEN = 256;
  localparam int AW  = $clog2(NC);
  localparam int IW  = $clog2(LEN);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [AW-1:0] addr = '0;
  logic sdi = 1'b0, sh = 1'b0, ld = 1'b0, rb = 1'b0, clr = 1'b0, up = 1'b0;
  logic [1:0] upc = '0;
  logic [IW-1:0] upi = '0;
  logic sdo;
  logic [NC*LEN-1:0] cfg;

  int n_chk = 0;
  int n_fail = 0;
  int cycles = 0;
  bit done = 1'b0;

  logic [LEN-1:0] exp_cfg [NC];

  always #4 clk = ~clk;

  cfg_shift_store #(.NUM_COLS(NC), .CHAIN_LEN(LEN)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .col_addr_i(addr), .sdi_i(sdi),
    .shift_i(sh), .load_i(ld), .rdbk_i(rb), .clear_i(clr),
    .upset_i(up), .upset_copy_i(upc), .upset_idx_i(upi),
    .sdo_o(sdo), .cfg_o(cfg)
  );

  function automatic logic [LEN-1:0] pat(int c);
    logic [LEN-1:0] v;
    for (int i = 0; i < LEN; i++)
      v[i] = ((((i * 5) + (c * 11) + (i >> 3)) % 3) == 0) ^ c[0];
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [LEN-1:0] act, logic [LEN-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_all(string req);
    for (int c = 0; c < NC; c++)
      chk(cfg[c*LEN +: LEN] == exp_cfg[c], req, cfg[c*LEN +: LEN], exp_cfg[c]);
  endtask

  task automatic shift_in(int c, logic [LEN-1:0] v);
    addr = AW'(c);
    for (int j = 0; j < LEN; j++) begin
      sdi = v[LEN-1-j];
      sh = 1'b1;
      @(negedge clk);
    end
    sh = 1'b0;
    sdi = 1'b0;
  endtask

  task automatic shift_out(int c, output logic [LEN-1:0] v);
    addr = AW'(c);
    for (int j = 0; j < LEN; j++) begin
      #1;
      v[LEN-1-j] = sdo;
      sh = 1'b1;
      @(negedge clk);
    end
    sh = 1'b0;
  endtask

  task automatic strobe(int c, bit l, bit r, bit k);
    addr = AW'(c);
    ld = l; rb = r; clr = k;
    @(negedge clk);
    ld = 1'b0; rb = 1'b0; clr = 1'b0;
  endtask

  task automatic upset(int c, int copy, int idx);
    addr = AW'(c);
    up = 1'b1; upc = 2'(copy); upi = IW'(idx);
    @(negedge clk);
    up = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected<150000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [LEN-1:0] rd;
    logic [LEN-1:0] v;
    for (int c = 0; c < NC; c++) exp_cfg[c] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sdo == 1'b0, "R1 sdo", LEN'(sdo), '0);
    chk_all("R1 cfg");
    rst_ni = 1'b1;
    @(negedge clk);

    // R5/R3: load each column, whole image checked after each
    for (int c = 0; c < NC; c++) begin
      shift_in(c, pat(c));
      strobe(c, 1, 0, 0);
      exp_cfg[c] = pat(c);
      chk_all("R5 R3 load image");
    end

    // R4: staging still holds patterns, sdo follows address
    for (int c = NC - 1; c >= 0; c--) begin
      addr = AW'(c);
      #1;
      chk(sdo == exp_cfg[c][LEN-1], "R4 sdo mux", LEN'(sdo), LEN'(exp_cfg[c][LEN-1]));
    end

    // R6/R2: overwrite staging, readback, shift out
    for (int c = 0; c < NC; c++) begin
      shift_in(c, ~pat(c));
      strobe(c, 0, 1, 0);
      shift_out(c, rd);
      chk(rd == exp_cfg[c], "R6 R2 readback", rd, exp_cfg[c]);
    end
    chk_all("R2 shift keeps cells");

    // R8 clear
    shift_in(5, pat(20));
    strobe(5, 0, 0, 1);
    addr = AW'(5); #1;
    chk(sdo == 1'b0, "R8 sdo after clear", LEN'(sdo), '0);
    shift_out(5, rd);
    chk(rd == '0, "R8 staging zero", rd, '0);
    chk_all("R8 cells kept");

    // R7 priority
    shift_in(3, ~exp_cfg[3]);
    strobe(3, 1, 1, 0);
    chk(cfg[3*LEN +: LEN] == exp_cfg[3], "R7 rdbk over load", cfg[3*LEN +: LEN], exp_cfg[3]);
    shift_out(3, rd);
    chk(rd == exp_cfg[3], "R7 rdbk wins staging", rd, exp_cfg[3]);
    shift_in(9, pat(33));
    strobe(9, 1, 1, 1);
    shift_out(9, rd);
    chk(rd == '0, "R7 clear first", rd, '0);
    chk_all("R7 clear keeps cells");
    v = pat(41);
    shift_in(2, v);
    addr = AW'(2); ld = 1'b1; sh = 1'b1; sdi = 1'b1;
    @(negedge clk);
    ld = 1'b0; sh = 1'b0; sdi = 1'b0;
    exp_cfg[2] = v;
    chk_all("R7 load over shift");
    shift_out(2, rd);
    chk(rd == v, "R7 no shift with load", rd, v);

    // R9/R10 upsets
    v = exp_cfg[7];
    upset(7, 0, 10);
    chk_all("R9 single upset masked");
    upset(7, 3, 11);
    chk_all("R10 copy 3 ignored");
    upset(7, 1, 10);
    exp_cfg[7][10] = ~exp_cfg[7][10];
    chk_all("R9 double upset flips");
    strobe(7, 0, 1, 0);
    shift_out(7, rd);
    chk(rd == exp_cfg[7], "R9 readback voted", rd, exp_cfg[7]);
    shift_in(7, v);
    strobe(7, 1, 0, 0);
    exp_cfg[7] = v;
    chk_all("R9 load repairs");
    upset(7, 2, 10);
    chk_all("R9 all copies rewritten");
    upset(8, 0, 200);
    upset(8, 2, 200);
    exp_cfg[8][200] = ~exp_cfg[8][200];
    chk_all("R3 upset only addressed column");
    // R10 load overrides same-cycle upset
    shift_in(8, pat(8));
    addr = AW'(8); ld = 1'b1; up = 1'b1; upc = 2'd0; upi = IW'(5);
    @(negedge clk);
    ld = 1'b0; up = 1'b0;
    exp_cfg[8] = pat(8);
    upset(8, 1, 5);
    chk_all("R10 load over upset");

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule